// File: doc/BRIEF.md
# Command Queue Consumer

This block drains a circular command ring that lives in system memory and feeds the control plane of an I/O memory management unit. Software fills ring slots and moves a producer index forward. The block compares that index with its own consumer index, fetches one 128-bit command at a time through a request/response memory port, decodes the opcode and acts on it. Invalidation commands become one-cycle strobes with the decoded address-space and virtual-machine identifiers. A completion (sync) command can request an interrupt pulse or an event pulse. All other legal commands are consumed with no further action.

The ring size is a power of two that software programs at run time. Each index register holds a slot number in its low log2-size bits and a wrap flag in the bit directly above. Comparing the two indexes, wrap flags included, tells an empty ring from a full one. When a command is illegal or its fetch comes back with an error, the block stops. It writes an error code into a 7-bit field of the consumer register and pulses a global-error strobe. It stays halted until software rewrites the consumer register with that field cleared.

Top module: `cmdq_consumer`

## Requirements
- R1: After reset the consumer register reads 0, the ring reports empty and not full, and no fetch is requested.
- R2: A fetch is requested only while bit 3 of the control register (select 0) is 1. Writing a control value with bit 3 clear, even with bits 2:0 set, starts no fetch.
- R3: With log2 size L, the ring is empty when index bits L-1:0 and wrap bit L of producer and consumer all match. It is full when the index bits match and the wrap bits differ. Bits above L play no part in either test.
- R4: The base register (select 1) takes the base address from write bits 51:6, with bits 5:0 of the address forced to zero. It takes L from write bits 4:0, clamped to MAX_LOG2. A command is fetched from base + 16 × (consumer index bits L-1:0).
- R5: Consuming a command adds one to consumer bits L:0 and wraps within them. Pointer bits above L and the error field in bits 30:24 keep their values.
- R6: Opcodes 0x03–0x07, 0x10–0x13, 0x18, 0x1A, 0x20–0x23, 0x28, 0x2A and 0x30 (word 0 bits 7:0) each give exactly one one-cycle invalidation strobe. The strobe carries the opcode, ASID = word 1 bits 31:16 and VMID = word 1 bits 15:0. Opcodes 0x01, 0x02, 0x40, 0x41, 0x44 and 0x45 are consumed with no strobe.
- R7: Opcode 0x46 (sync) reads word 0 bits 13:12. Value 1 gives one interrupt pulse, value 2 gives one event pulse, value 0 gives neither, and value 3 is treated as an illegal command.
- R8: Any opcode outside R6 and R7 sets error code 1 in consumer bits 30:24 and pulses the global-error strobe. The consumer index does not move, and no further fetch is made while the error field is non-zero.
- R9: A fetch response flagged as an error sets error code 2 and pulses the global-error strobe. The consumer index does not move.
- R10: A software write to the consumer register (select 3) loads bits L:0 and bits 30:24. With bits 30:24 zero, consumption resumes from the written index.
- R11: At most one fetch is outstanding. The request is a single-cycle pulse, and no new one is made until its response arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regSel | input | 2 | Register select: 0 control, 1 base/size, 2 producer, 3 consumer |
| regWdata | input | 64 | Register write data |
| consReg | output | 32 | Consumer register: bits 30:24 error, bits MAX_LOG2:0 pointer |
| cmdqEmpty | output | 1 | Ring empty |
| cmdqFull | output | 1 | Ring full |
| memReq | output | 1 | Single-cycle fetch request |
| memAddr | output | ADDR_W | Fetch byte address |
| memRspValid | input | 1 | Fetch response valid |
| memRspErr | input | 1 | Fetch response error |
| memRspData | input | 128 | Command entry, word 0 in bits 31:0 |
| invStrobe | output | 1 | Invalidation strobe |
| invOp | output | 8 | Invalidation opcode |
| invAsid | output | 16 | Decoded ASID |
| invVmid | output | 16 | Decoded VMID |
| syncIrq | output | 1 | Sync completion interrupt pulse |
| syncEvt | output | 1 | Sync completion event pulse |
| gerrStrobe | output | 1 | Global-error pulse |

## Verification
The bench builds the block with its default parameters: MAX_LOG2 = 8 and a 52-bit address. It programs a log2 size of 4 for the decode and error tests and 2 for the wrap test. At size 2 a four-slot ring becomes full, wraps its index and flips its wrap bit within a handful of commands. In that same test a consumer bit above the wrap position is set, which shows that increments leave it alone.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;
  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_BASE = 2'd1;
  localparam logic [1:0] SEL_PROD = 2'd2;
  localparam logic [1:0] SEL_CONS = 2'd3;

  localparam logic [6:0] ERR_NONE     = 7'd0;
  localparam logic [6:0] ERR_ILLEGAL  = 7'd1;
  localparam logic [6:0] ERR_ABORT    = 7'd2;
  localparam logic [6:0] ERR_ATC_SYNC = 7'd3;

  localparam int CTRL_EN_BIT = 3;

  typedef enum logic [2:0] {
    CLS_BAD, CLS_PLAIN, CLS_INVAL, CLS_SYNC_IRQ, CLS_SYNC_EVT
  } cmdClass_e;

  typedef struct packed {
    logic       issue;
    logic       advance;
    logic       setErr;
    logic [6:0] errCode;
    logic       fireInval;
    logic       fireIrq;
    logic       fireEvt;
  } ctrlStb_t;

  function automatic cmdClass_e classify(input logic [7:0] op, input logic [1:0] cs);
    cmdClass_e c;
    case (op)
      8'h01, 8'h02, 8'h40, 8'h41, 8'h44, 8'h45: c = CLS_PLAIN;
      8'h03, 8'h04, 8'h05, 8'h06, 8'h07,
      8'h10, 8'h11, 8'h12, 8'h13, 8'h18, 8'h1A,
      8'h20, 8'h21, 8'h22, 8'h23, 8'h28, 8'h2A, 8'h30: c = CLS_INVAL;
      8'h46: begin
        case (cs)
          2'd0:    c = CLS_PLAIN;
          2'd1:    c = CLS_SYNC_IRQ;
          2'd2:    c = CLS_SYNC_EVT;
          default: c = CLS_BAD;
        endcase
      end
      default: c = CLS_BAD;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/cmdq_datapath.sv
module cmdq_datapath
  import cmdq_pkg::*;
#(
  parameter int MAX_LOG2 = 8,
  parameter int ADDR_W   = 52
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWe,
  input  logic [1:0]           regSel,
  input  logic [63:0]          regWdata,
  input  ctrlStb_t             stb,
  input  logic [127:0]         rspData,
  output logic [ADDR_W-1:0]    memAddr,
  output logic [31:0]          consReg,
  output logic                 cmdqEmpty,
  output logic                 cmdqFull,
  output logic                 errActive,
  output logic                 qEnable,
  output cmdClass_e            cmdClass,
  output logic                 invStrobe,
  output logic [7:0]           invOp,
  output logic [15:0]          invAsid,
  output logic [15:0]          invVmid,
  output logic                 syncIrq,
  output logic                 syncEvt,
  output logic                 gerrStrobe
);
  localparam int PTR_W = MAX_LOG2 + 1;
  localparam int L2_W  = $clog2(MAX_LOG2 + 1);

  logic [ADDR_W-1:6] baseR;
  logic [L2_W-1:0]   log2R;
  logic [PTR_W-1:0]  prodR, consPtrR, consNext;
  logic [6:0]        consErrR;
  logic [PTR_W-1:0]  wrapBit, wrapIdxMask, idxMask, ptrDiff, slotIdx;
  logic              unusedBits;

  assign unusedBits = ^{regWdata, rspData[127:64], rspData[31:14], rspData[11:8]};

  // Run-time masks derived from the programmed size
  always_comb begin
    wrapBit     = PTR_W'(1) << log2R;
    wrapIdxMask = (wrapBit << 1) - PTR_W'(1);
    idxMask     = wrapBit - PTR_W'(1);
    ptrDiff     = (consPtrR ^ prodR) & wrapIdxMask;
    consNext    = (consPtrR & ~wrapIdxMask) | ((consPtrR + PTR_W'(1)) & wrapIdxMask);
    slotIdx     = consPtrR & idxMask;
  end

  assign cmdqEmpty = (ptrDiff == '0);
  assign cmdqFull  = (ptrDiff == wrapBit);
  assign errActive = (consErrR != ERR_NONE);
  assign memAddr   = {baseR, 6'b0} + (ADDR_W'(slotIdx) << 4);
  assign cmdClass  = classify(rspData[7:0], rspData[13:12]);

  always_comb begin
    consReg = '0;
    consReg[30:24] = consErrR;
    consReg[PTR_W-1:0] = consPtrR;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      qEnable  <= 1'b0;
      baseR    <= '0;
      log2R    <= '0;
      prodR    <= '0;
      consPtrR <= '0;
      consErrR <= ERR_NONE;
    end else begin
      if (regWe && regSel == SEL_CTRL) qEnable <= regWdata[CTRL_EN_BIT];
      if (regWe && regSel == SEL_BASE) begin
        baseR <= regWdata[ADDR_W-1:6];
        log2R <= (regWdata[4:0] > 5'(MAX_LOG2)) ? L2_W'(MAX_LOG2) : L2_W'(regWdata[4:0]);
      end
      if (regWe && regSel == SEL_PROD) prodR <= regWdata[PTR_W-1:0];
      // Software write wins over a hardware update in the same cycle
      if (regWe && regSel == SEL_CONS) begin
        consPtrR <= regWdata[PTR_W-1:0];
        consErrR <= regWdata[30:24];
      end else begin
        if (stb.advance) consPtrR <= consNext;
        if (stb.setErr)  consErrR <= stb.errCode;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      invStrobe  <= 1'b0;
      invOp      <= '0;
      invAsid    <= '0;
      invVmid    <= '0;
      syncIrq    <= 1'b0;
      syncEvt    <= 1'b0;
      gerrStrobe <= 1'b0;
    end else begin
      invStrobe  <= stb.fireInval;
      syncIrq    <= stb.fireIrq;
      syncEvt    <= stb.fireEvt;
      gerrStrobe <= stb.setErr;
      if (stb.fireInval) begin
        invOp   <= rspData[7:0];
        invAsid <= rspData[63:48];
        invVmid <= rspData[47:32];
      end
    end
  end
endmodule

// File: rtl/cmdq_ctrl.sv
module cmdq_ctrl
  import cmdq_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      qEnable,
  input  logic      cmdqEmpty,
  input  logic      errActive,
  input  logic      consWrite,
  input  logic      rspValid,
  input  logic      rspErr,
  input  cmdClass_e cmdClass,
  output logic      memReq,
  output ctrlStb_t  stb
);
  typedef enum logic {ST_IDLE, ST_WAIT} state_e;
  state_e state;
  logic   canIssue, rspTaken;

  assign canIssue = (state == ST_IDLE) && qEnable && !cmdqEmpty && !errActive && !consWrite;
  assign rspTaken = (state == ST_WAIT) && rspValid;
  assign memReq   = canIssue;

  always_comb begin
    stb = '0;
    stb.issue = canIssue;
    if (rspTaken) begin
      if (rspErr) begin
        stb.setErr  = 1'b1;
        stb.errCode = ERR_ABORT;
      end else begin
        case (cmdClass)
          CLS_PLAIN:    stb.advance = 1'b1;
          CLS_INVAL:    begin stb.advance = 1'b1; stb.fireInval = 1'b1; end
          CLS_SYNC_IRQ: begin stb.advance = 1'b1; stb.fireIrq = 1'b1; end
          CLS_SYNC_EVT: begin stb.advance = 1'b1; stb.fireEvt = 1'b1; end
          default: begin
            stb.setErr  = 1'b1;
            stb.errCode = ERR_ILLEGAL;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else if (canIssue) state <= ST_WAIT;
    else if (rspTaken) state <= ST_IDLE;
  end
endmodule

// File: rtl/cmdq_consumer.sv
module cmdq_consumer
  import cmdq_pkg::*;
#(
  parameter int MAX_LOG2 = 8,
  parameter int ADDR_W   = 52
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [1:0]        regSel,
  input  logic [63:0]       regWdata,
  output logic [31:0]       consReg,
  output logic              cmdqEmpty,
  output logic              cmdqFull,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memRspValid,
  input  logic              memRspErr,
  input  logic [127:0]      memRspData,
  output logic              invStrobe,
  output logic [7:0]        invOp,
  output logic [15:0]       invAsid,
  output logic [15:0]       invVmid,
  output logic              syncIrq,
  output logic              syncEvt,
  output logic              gerrStrobe
);
  ctrlStb_t  stb;
  cmdClass_e cmdClass;
  logic      errActive, qEnable, consWrite;

  assign consWrite = regWe && (regSel == SEL_CONS);

  cmdq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .qEnable(qEnable), .cmdqEmpty(cmdqEmpty),
    .errActive(errActive), .consWrite(consWrite), .rspValid(memRspValid),
    .rspErr(memRspErr), .cmdClass(cmdClass), .memReq(memReq), .stb(stb)
  );

  cmdq_datapath #(.MAX_LOG2(MAX_LOG2), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regSel(regSel), .regWdata(regWdata),
    .stb(stb), .rspData(memRspData), .memAddr(memAddr), .consReg(consReg),
    .cmdqEmpty(cmdqEmpty), .cmdqFull(cmdqFull), .errActive(errActive),
    .qEnable(qEnable), .cmdClass(cmdClass), .invStrobe(invStrobe), .invOp(invOp),
    .invAsid(invAsid), .invVmid(invVmid), .syncIrq(syncIrq), .syncEvt(syncEvt),
    .gerrStrobe(gerrStrobe)
  );
endmodule

// File: rtl/cmdq_consumer_chk.sv
module cmdq_consumer_chk #(
  parameter int MAX_LOG2 = 8
) (
  input logic        clk,
  input logic        rstN,
  input logic        regWe,
  input logic [1:0]  regSel,
  input logic [31:0] consReg,
  input logic        cmdqEmpty,
  input logic        cmdqFull,
  input logic        memReq,
  input logic        memRspValid,
  input logic        memRspErr,
  input logic        invStrobe,
  input logic        gerrStrobe,
  input logic        qEnable
);
  localparam int PTR_W = MAX_LOG2 + 1;
  logic unusedCons;
  assign unusedCons = ^consReg;

  // R11
  one_req_chk: assert property (@(posedge clk) disable iff (!rstN) memReq |=> !memReq);
  // R2
  req_enabled_chk: assert property (@(posedge clk) disable iff (!rstN) memReq |-> qEnable);
  // R8
  req_no_err_chk: assert property (@(posedge clk) disable iff (!rstN) memReq |-> consReg[30:24] == 7'd0);
  // R3
  req_not_empty_chk: assert property (@(posedge clk) disable iff (!rstN) memReq |-> !cmdqEmpty);
  // R3
  empty_full_excl_chk: assert property (@(posedge clk) disable iff (!rstN) !(cmdqEmpty && cmdqFull));
  // R6
  inv_pulse_chk: assert property (@(posedge clk) disable iff (!rstN) invStrobe |=> !invStrobe);
  // R8
  gerr_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    (gerrStrobe && !$past(regWe && regSel == 2'd3)) |-> consReg[30:24] != 7'd0);
  // R9
  abort_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memRspValid && memRspErr && !regWe) |=> $stable(consReg[PTR_W-1:0]));
  // R10
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (consReg[30:24] != 7'd0 && !regWe) |=> $stable(consReg));
endmodule

bind cmdq_consumer cmdq_consumer_chk #(.MAX_LOG2(MAX_LOG2)) u_chk (
  .clk(clk), .rstN(rstN), .regWe(regWe), .regSel(regSel), .consReg(consReg),
  .cmdqEmpty(cmdqEmpty), .cmdqFull(cmdqFull), .memReq(memReq),
  .memRspValid(memRspValid), .memRspErr(memRspErr), .invStrobe(invStrobe),
  .gerrStrobe(gerrStrobe), .qEnable(qEnable)
);

// File: tb/tb_cmdq_consumer.sv
module tb_cmdq_consumer;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         regWe = 1'b0;
  logic [1:0]   regSel = 2'd0;
  logic [63:0]  regWdata = '0;
  logic [31:0]  consReg;
  logic         cmdqEmpty, cmdqFull, memReq;
  logic [51:0]  memAddr;
  logic         memRspValid, memRspErr;
  logic [127:0] memRspData;
  logic         invStrobe, syncIrq, syncEvt, gerrStrobe;
  logic [7:0]   invOp;
  logic [15:0]  invAsid, invVmid;

  int checks = 0, fails = 0;
  int reqCnt = 0, invCnt = 0, irqCnt = 0, evtCnt = 0, gerrCnt = 0;
  logic [51:0]  lastAddr = '0;
  logic [127:0] mem [256];
  logic         badEn = 1'b0;
  logic [51:0]  badAddr = '0;
  bit           done = 1'b0;

  always #2 clk = ~clk;

  cmdq_consumer dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regSel(regSel), .regWdata(regWdata),
    .consReg(consReg), .cmdqEmpty(cmdqEmpty), .cmdqFull(cmdqFull), .memReq(memReq),
    .memAddr(memAddr), .memRspValid(memRspValid), .memRspErr(memRspErr),
    .memRspData(memRspData), .invStrobe(invStrobe), .invOp(invOp), .invAsid(invAsid),
    .invVmid(invVmid), .syncIrq(syncIrq), .syncEvt(syncEvt), .gerrStrobe(gerrStrobe)
  );

  // Memory model: one-cycle response latency
  always @(posedge clk) begin
    if (!rstN) begin
      memRspValid <= 1'b0;
      memRspErr   <= 1'b0;
      memRspData  <= '0;
    end else begin
      memRspValid <= memReq;
      memRspErr   <= memReq && badEn && (memAddr == badAddr);
      memRspData  <= mem[memAddr[11:4]];
    end
  end

  always @(posedge clk) begin
    if (rstN) begin
      if (memReq) begin reqCnt <= reqCnt + 1; lastAddr <= memAddr; end
      if (invStrobe) invCnt <= invCnt + 1;
      if (syncIrq) irqCnt <= irqCnt + 1;
      if (syncEvt) evtCnt <= evtCnt + 1;
      if (gerrStrobe) gerrCnt <= gerrCnt + 1;
    end
  end

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] sel, input logic [63:0] d);
    @(negedge clk);
    regWe = 1'b1; regSel = sel; regWdata = d;
    @(negedge clk);
    regWe = 1'b0; regWdata = '0;
  endtask

  task automatic putCmd(input int slot, input logic [31:0] w0, input logic [31:0] w1);
    mem[slot] = {64'h0, w1, w0};
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    settle(2);
    check("R1 consumer reset", consReg, 0);
    check("R1 empty reset", cmdqEmpty, 1);
    check("R1 full reset", cmdqFull, 0);
    check("R1 no request", reqCnt, 0);
  endtask

  task automatic t_gating();
    regWrite(2'd1, 64'h10024);           // base 0x10000 (bit 5 dropped), log2 4
    putCmd(0, 32'h0000_0012, 32'hABCD_1234);
    putCmd(1, 32'h0000_0001, 32'h0);
    putCmd(2, 32'h0000_1046, 32'h0);
    regWrite(2'd0, 64'h7);
    regWrite(2'd2, 64'd3);
    settle(20);
    check("R2 no fetch while disabled", reqCnt, 0);
    check("R2 consumer held", consReg, 0);
    check("R3 not empty", cmdqEmpty, 0);
    check("R3 not full", cmdqFull, 0);
    regWrite(2'd0, 64'h8);
    settle(30);
    check("R5 consumer advanced", consReg, 3);
    check("R3 empty after drain", cmdqEmpty, 1);
    check("R4 slot 2 address", lastAddr, 52'h10020);
    check("R11 one fetch per command", reqCnt, 3);
    check("R6 inval count", invCnt, 1);
    check("R6 opcode", invOp, 8'h12);
    check("R6 asid", invAsid, 16'hABCD);
    check("R6 vmid", invVmid, 16'h1234);
    check("R7 irq pulse", irqCnt, 1);
    check("R7 no event", evtCnt, 0);
  endtask

  task automatic t_sync();
    putCmd(3, 32'h0000_2046, 32'h0);
    putCmd(4, 32'h0000_0046, 32'h0);
    regWrite(2'd2, 64'd5);
    settle(20);
    check("R7 consumer after sync", consReg, 5);
    check("R7 event pulse", evtCnt, 1);
    check("R7 irq unchanged", irqCnt, 1);
  endtask

  task automatic t_illegal();
    int reqBefore;
    putCmd(5, 32'h0000_0009, 32'h0);
    putCmd(6, 32'h0000_0010, 32'h0005_0006);
    regWrite(2'd2, 64'd7);
    settle(20);
    check("R8 error code 1, index held", consReg, 32'h0100_0005);
    check("R8 gerr pulse", gerrCnt, 1);
    check("R8 no inval", invCnt, 1);
    reqBefore = reqCnt;
    settle(20);
    check("R8 halted", reqCnt, reqBefore);
    regWrite(2'd3, 64'd6);
    settle(20);
    check("R10 resumed", consReg, 7);
    check("R10 inval after resume", invCnt, 2);
    check("R6 asid 2", invAsid, 16'h0005);
    check("R6 vmid 2", invVmid, 16'h0006);
  endtask

  task automatic t_cs3();
    putCmd(7, 32'h0000_3046, 32'h0);
    regWrite(2'd2, 64'd8);
    settle(20);
    check("R7 sync field 3 illegal", consReg, 32'h0100_0007);
    check("R7 no pulses", irqCnt + evtCnt, 2);
    regWrite(2'd3, 64'd8);
    settle(10);
    check("R10 cleared", consReg, 8);
  endtask

  task automatic t_abort();
    putCmd(8, 32'h0000_0003, 32'h0);
    badAddr = 52'h10080; badEn = 1'b1;
    regWrite(2'd2, 64'd9);
    settle(20);
    check("R9 abort code 2", consReg, 32'h0200_0008);
    check("R9 gerr pulse", gerrCnt, 3);
    check("R9 no inval", invCnt, 2);
    badEn = 1'b0;
    regWrite(2'd3, 64'd8);
    settle(20);
    check("R10 refetch ok", consReg, 9);
    check("R6 config inval", invOp, 8'h03);
  endtask

  task automatic t_wrap();
    regWrite(2'd0, 64'h0);
    regWrite(2'd1, 64'h10002);          // log2 2: four slots
    for (int i = 0; i < 4; i++) putCmd(i, 32'h0000_0001, 32'h0);
    regWrite(2'd3, 64'h80);             // bit 7 above wrap position
    regWrite(2'd2, 64'h4);
    settle(2);
    check("R3 full", cmdqFull, 1);
    check("R3 not empty when full", cmdqEmpty, 0);
    regWrite(2'd0, 64'h8);
    settle(20);
    check("R5 wrap bit set, high bit kept", consReg, 32'h84);
    check("R3 empty after wrap", cmdqEmpty, 1);
    regWrite(2'd2, 64'h7);
    settle(20);
    check("R5 consumer 7", consReg, 32'h87);
    regWrite(2'd2, 64'h0);
    settle(20);
    check("R5 index wraps to 0", consReg, 32'h80);
    check("R4 slot 3 address", lastAddr, 52'h10030);
    check("R3 empty at end", cmdqEmpty, 1);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_gating();
    t_sync();
    t_illegal();
    t_cs3();
    t_abort();
    t_wrap();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired got=1 exp=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule